// File: doc/BRIEF.md
# Triggered Look-Back Capture with Alternating Event Buffers

The block takes a free-running stream of ADC samples, one row per clock with one 14-bit sample for each of 16 channels, and keeps the most recent 512 rows in a circular history memory. That is about 4 us of history at an 8 ns sample period. A trigger pulse freezes a window of 32 consecutive rows per channel (256 ns) into an event buffer. The window ends a programmable number of samples before the trigger, so the pulse that caused the trigger falls inside the window even though the trigger decision arrives late. The window covers all 16 channels on every trigger.

There are two event buffers, used alternately. While one is being drained through the readout stream, the other can accept the next event. A buffer is handed back to the capture side only after its last word has been transferred. A trigger that finds both buffers occupied is discarded, and a sticky overflow flag records the loss. Readout is a valid/ready stream. The block holds the current word and its flags unchanged for as long as the consumer withholds ready, and back-pressure only delays the drain. The sample side carries a valid strobe but no ready, because an ADC cannot be stalled. Rows with the strobe low are simply not recorded.

Top module: `tpc_capture_top`

## Requirements
- R1: An event holds, for each channel, the 32 samples whose ages are L+31 down to L. Age 0 is the most recent sample accepted in or before the cycle in which the trigger is taken, and L is the `lookback` value registered in that cycle.
- R2: A `lookback` value above 480 is treated as 480.
- R3: Readout is channel-major: channel 0 samples oldest to newest, then channel 1, and so on. Each word is `{channel[3:0], sample[13:0]}`. `out_last` is high on the 512th word of an event and only while `out_valid` is high.
- R4: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold their values. No word is skipped or repeated.
- R5: Successive events go to alternating buffers. Two events can be held while readout is stalled (`buf_full` = 2'b11), and they are read out in trigger order.
- R6: A trigger during the 32 cycles after an accepted trigger is ignored. It creates no event and does not set `overflow`.
- R7: A trigger arriving when both buffers are full is discarded and sets `overflow`, which stays high until reset. The stored events are unchanged.
- R8: After reset, `buf_full` is 2'b00 and `out_valid` and `overflow` are low.
- R9: If a trigger is taken in cycle T, `out_valid` is low through cycle T+32 and high from cycle T+33, given that readout was idle. A buffer's `buf_full` bit clears on the handshake of its last word.
- R10: Rows presented with `in_valid` low are not recorded. Ages in R1 count accepted rows only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The sample row on `in_data` is valid this cycle |
| in_data | input | 224 | One 14-bit sample per channel; channel c at bits [14c+13:14c] |
| trig | input | 1 | Trigger request, sampled every cycle |
| lookback | input | 9 | Samples between window end and the trigger, clamped to 480 |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 18 | Channel index and sample |
| out_last | output | 1 | Final word of the event |
| buf_full | output | 2 | Per-buffer occupied flag |
| overflow | output | 1 | Sticky flag for a discarded trigger |

## Verification
The hardest condition to reach is a trigger that lands while both buffers are occupied. It needs two completed captures with no drain between them, followed by a third pulse. The bench withholds `out_ready` entirely while it fires three spaced triggers, then drains both events and compares them word by word to show that the discarded trigger disturbed neither. The other hard case is the limit of the history depth: a look-back of 480 or more puts the oldest captured row right beside the slot being overwritten. A clamped value is applied and the exact window contents are checked.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned TPC_NUM_CH = 16;
  localparam int unsigned TPC_SMP_W  = 14;
  localparam int unsigned TPC_HIST   = 512;
  localparam int unsigned TPC_WIN    = 32;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/tpc_hist_ring.sv
module tpc_hist_ring #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SMP_W  = 14,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned ROW_W = NUM_CH * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_row,
  output logic [AW-1:0]    wptr_next
);
  logic [ROW_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;

  // wptr_next counts the row accepted this cycle, so a trigger sees it as age 0
  assign wptr_next = wptr + AW'(wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n) wptr <= '0;
    else        wptr <= wptr_next;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_row;
  end

  // read happens before this cycle's write lands, so the oldest slot is still intact
  assign rd_row = mem[rd_addr];
endmodule

// File: rtl/tpc_cap_ctrl.sv
module tpc_cap_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIN   = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned WW   = $clog2(WIN),
  localparam int unsigned MAX_LB = DEPTH - WIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [AW-1:0] lookback,
  input  logic [AW-1:0] wptr_next,
  input  logic          rd_done,
  input  logic          rd_sel,
  output logic [AW-1:0] hist_addr,
  output logic          cap_we,
  output logic          cap_sel,
  output logic [WW-1:0] cap_idx,
  output logic [1:0]    buf_full,
  output logic          overflow,
  output logic          busy
);
  cap_state_e    state;
  logic [AW-1:0] start_q;
  logic [AW-1:0] lb_eff;
  logic [AW-1:0] start_c;
  logic [WW-1:0] cnt;
  logic          cnt_last;
  logic          take;
  logic          drop;
  logic [1:0]    full_nxt;

  assign lb_eff   = (lookback > AW'(MAX_LB)) ? AW'(MAX_LB) : lookback;
  assign start_c  = wptr_next - lb_eff - AW'(WIN);
  assign busy     = (state == CAP_RUN);
  assign cnt_last = (cnt == WW'(WIN - 1));
  assign take     = trig && !busy && !buf_full[cap_sel];
  assign drop     = trig && !busy &&  buf_full[cap_sel];

  assign hist_addr = start_q + AW'(cnt);
  assign cap_we    = busy;
  assign cap_idx   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= CAP_IDLE;
      cnt     <= '0;
      start_q <= '0;
      cap_sel <= 1'b0;
    end else begin
      unique case (state)
        CAP_IDLE: begin
          if (take) begin
            state   <= CAP_RUN;
            cnt     <= '0;
            start_q <= start_c;
          end
        end
        CAP_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt_last) begin
            state   <= CAP_IDLE;
            cap_sel <= ~cap_sel;
          end
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  always_comb begin
    full_nxt = buf_full;
    for (int b = 0; b < 2; b++) begin
      if (busy && cnt_last && (cap_sel == b[0])) full_nxt[b] = 1'b1;
      if (rd_done && (rd_sel == b[0]))           full_nxt[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 2'b00;
      overflow <= 1'b0;
    end else begin
      buf_full <= full_nxt;
      overflow <= overflow | drop;
    end
  end
endmodule

// File: rtl/tpc_evt_store.sv
module tpc_evt_store #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SMP_W  = 14,
  parameter int unsigned WIN    = 32,
  localparam int unsigned CW    = $clog2(NUM_CH),
  localparam int unsigned WW    = $clog2(WIN),
  localparam int unsigned ROW_W = NUM_CH * SMP_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wsel,
  input  logic [WW-1:0]    widx,
  input  logic [ROW_W-1:0] wrow,
  input  logic             rsel,
  input  logic [CW-1:0]    rch,
  input  logic [WW-1:0]    rsmp,
  output logic [SMP_W-1:0] rdata
);
  logic [ROW_W-1:0] rd_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    logic [SMP_W-1:0] bank [2*WIN];
    always_ff @(posedge clk) begin
      if (we) bank[{wsel, widx}] <= wrow[c*SMP_W +: SMP_W];
    end
    assign rd_all[c*SMP_W +: SMP_W] = bank[{rsel, rsmp}];
  end

  assign rdata = rd_all[32'(rch)*SMP_W +: SMP_W];
endmodule

// File: rtl/tpc_rd_port.sv
module tpc_rd_port #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned WIN    = 32,
  localparam int unsigned CW    = $clog2(NUM_CH),
  localparam int unsigned WW    = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    buf_full,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          rd_sel,
  output logic [CW-1:0] rch,
  output logic [WW-1:0] rsmp,
  output logic          rd_done
);
  logic fire;
  logic smp_end;

  assign out_valid = buf_full[rd_sel];
  assign smp_end   = (rsmp == WW'(WIN - 1));
  assign out_last  = out_valid && smp_end && (rch == CW'(NUM_CH - 1));
  assign fire      = out_valid && out_ready;
  assign rd_done   = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsmp   <= '0;
      rch    <= '0;
      rd_sel <= 1'b0;
    end else if (fire) begin
      if (smp_end) begin
        rsmp <= '0;
        rch  <= out_last ? '0 : rch + 1'b1;
      end else begin
        rsmp <= rsmp + 1'b1;
      end
      if (out_last) rd_sel <= ~rd_sel;
    end
  end
endmodule

// File: rtl/tpc_capture_top.sv
module tpc_capture_top
  import tpc_pkg::*;
#(
  parameter int unsigned NUM_CH     = TPC_NUM_CH,
  parameter int unsigned SMP_W      = TPC_SMP_W,
  parameter int unsigned HIST_DEPTH = TPC_HIST,
  parameter int unsigned WIN        = TPC_WIN
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [NUM_CH*SMP_W-1:0]           in_data,
  input  logic                              trig,
  input  logic [$clog2(HIST_DEPTH)-1:0]     lookback,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [$clog2(NUM_CH)+SMP_W-1:0]   out_data,
  output logic                              out_last,
  output logic [1:0]                        buf_full,
  output logic                              overflow
);
  localparam int unsigned AW    = $clog2(HIST_DEPTH);
  localparam int unsigned CW    = $clog2(NUM_CH);
  localparam int unsigned WW    = $clog2(WIN);
  localparam int unsigned ROW_W = NUM_CH * SMP_W;

  logic [AW-1:0]    wptr_next;
  logic [AW-1:0]    hist_addr;
  logic [ROW_W-1:0] hist_row;
  logic             cap_we;
  logic             cap_sel;
  logic [WW-1:0]    cap_idx;
  logic             cap_busy;
  logic             rd_sel;
  logic             rd_done;
  logic [CW-1:0]    rch;
  logic [WW-1:0]    rsmp;
  logic [SMP_W-1:0] rdata;

  tpc_hist_ring #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .DEPTH(HIST_DEPTH)) hist_i (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_row(in_data),
    .rd_addr(hist_addr), .rd_row(hist_row), .wptr_next(wptr_next)
  );

  tpc_cap_ctrl #(.DEPTH(HIST_DEPTH), .WIN(WIN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .lookback(lookback),
    .wptr_next(wptr_next), .rd_done(rd_done), .rd_sel(rd_sel),
    .hist_addr(hist_addr), .cap_we(cap_we), .cap_sel(cap_sel),
    .cap_idx(cap_idx), .buf_full(buf_full), .overflow(overflow),
    .busy(cap_busy)
  );

  tpc_evt_store #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .WIN(WIN)) store_i (
    .clk(clk), .we(cap_we), .wsel(cap_sel), .widx(cap_idx), .wrow(hist_row),
    .rsel(rd_sel), .rch(rch), .rsmp(rsmp), .rdata(rdata)
  );

  tpc_rd_port #(.NUM_CH(NUM_CH), .WIN(WIN)) rd_i (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .out_ready(out_ready),
    .out_valid(out_valid), .out_last(out_last), .rd_sel(rd_sel),
    .rch(rch), .rsmp(rsmp), .rd_done(rd_done)
  );

  assign out_data = {rch, rdata};
endmodule

// File: rtl/tpc_capture_chk.sv
module tpc_capture_chk #(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned WIN   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [OUT_W-1:0] out_data,
  input logic [1:0]       buf_full,
  input logic             overflow,
  input logic             cap_busy
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_len <= 0;
    else if (cap_busy) busy_len <= busy_len + 1;
    else               busy_len <= 0;
  end

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(trig && buf_full == 2'b11));

  a_r9_free_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(buf_full) < $past($countones(buf_full)))
      |-> $past(out_valid && out_ready && out_last));

  a_r6_capture_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_busy) |-> busy_len == WIN);

  a_r9_valid_has_event: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> buf_full != 2'b00);
endmodule

bind tpc_capture_top tpc_capture_chk #(
  .OUT_W($clog2(NUM_CH) + SMP_W),
  .WIN(WIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trig(trig), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .buf_full(buf_full), .overflow(overflow), .cap_busy(cap_busy)
);

// File: tb/tpc_capture_top_tb_top.sv
module tpc_capture_top_tb_top;
  localparam int NCH = 16;
  localparam int SW  = 14;
  localparam int WIN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [NCH*SW-1:0] in_data = '0;
  logic            trig = 1'b0;
  logic [8:0]      lookback = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [17:0]     out_data;
  logic            out_last;
  logic [1:0]      buf_full;
  logic            overflow;

  int n_chk = 0;
  int n_bad = 0;
  int acc = 0;
  int cyc = 0;
  int trig_n = 0;
  bit trig_req = 1'b0;
  bit gap_mode = 1'b0;

  always #10 clk = ~clk;

  tpc_capture_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .trig(trig), .lookback(lookback), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .buf_full(buf_full), .overflow(overflow)
  );

  function automatic logic [13:0] smp_val(int idx, int ch);
    return 14'((idx * 37 + ch * 1021 + 5) & 16383);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // single driver for samples and trigger, acting on falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      in_valid = gap_mode ? (cyc % 3 != 0) : 1'b1;
      if (in_valid) begin
        for (int c = 0; c < NCH; c++) in_data[c*SW +: SW] = smp_val(acc, c);
        acc++;
      end
      trig = trig_req;
      if (trig_req) begin
        trig_n = acc;
        trig_req = 1'b0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (600) @(posedge clk);
  endtask

  // returns count of accepted rows through the trigger cycle
  task automatic fire(input int lb, input bit chk_lat, output int n);
    @(posedge clk);
    lookback = 9'(lb);
    trig_req = 1'b1;
    @(posedge clk);
    n = trig_n;
    if (chk_lat) begin
      repeat (31) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid low at T+32", out_valid, 0);
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1, "R9 valid high at T+33", out_valid, 1);
    end
  endtask

  task automatic drain(input int n, input int l_eff, input bit stall, input bit bsel);
    int i = 0;
    int guard = 0;
    int pc = 0;
    bit held = 1'b0;
    logic [17:0] held_d = '0;
    logic [17:0] exp;
    int start = n - l_eff - WIN;
    while (i < NCH * WIN && guard < 20000) begin
      @(negedge clk);
      guard++;
      pc++;
      if (held) begin
        chk(out_valid && out_data == held_d, "R4 hold under stall", out_data, held_d);
        held = 1'b0;
      end
      out_ready = stall ? (pc % 4 != 1) : 1'b1;
      if (out_valid) begin
        if (out_ready) begin
          exp = {4'(i / WIN), smp_val(start + (i % WIN), i / WIN)};
          chk(out_data == exp, "R1/R3 word", out_data, exp);
          if (i == NCH * WIN - 1 || i == 0)
            chk(out_last == (i == NCH * WIN - 1), "R3 last flag", out_last, (i == NCH * WIN - 1));
          i++;
        end else begin
          held = 1'b1;
          held_d = out_data;
        end
      end
    end
    chk(guard < 20000, "R3 drain completes", guard, NCH * WIN);
    @(negedge clk);
    out_ready = 1'b0;
    chk(buf_full[bsel] == 1'b0, "R9 buffer freed after drain", buf_full, 0);
  endtask

  task automatic t_reset();
    chk(buf_full == 2'b00, "R8 buf_full reset", buf_full, 0);
    chk(out_valid == 1'b0, "R8 out_valid reset", out_valid, 0);
    chk(overflow == 1'b0, "R8 overflow reset", overflow, 0);
  endtask

  task automatic t_basic();
    int n;
    fire(0, 1'b1, n);
    drain(n, 0, 1'b0, 1'b0);
  endtask

  task automatic t_lookback();
    int n;
    fire(200, 1'b0, n);
    repeat (40) @(posedge clk);
    drain(n, 200, 1'b1, 1'b1);
  endtask

  task automatic t_clamp();
    int n;
    fire(500, 1'b0, n);
    repeat (40) @(posedge clk);
    drain(n, 480, 1'b0, 1'b0);   // R2
    fire(511, 1'b0, n);
    repeat (40) @(posedge clk);
    drain(n, 480, 1'b1, 1'b1);   // R2
  endtask

  task automatic t_pingpong();
    int na;
    int nb;
    fire(10, 1'b0, na);
    repeat (40) @(posedge clk);
    fire(300, 1'b0, nb);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(buf_full == 2'b11, "R5 two events held", buf_full, 3);
    drain(na, 10, 1'b0, 1'b0);
    drain(nb, 300, 1'b1, 1'b1);
  endtask

  task automatic t_busy_ignore();
    int n;
    int dummy;
    fire(5, 1'b0, n);
    repeat (10) @(posedge clk);
    fire(77, 1'b0, dummy);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk($countones(buf_full) == 1, "R6 one event only", buf_full, 1);
    chk(overflow == 1'b0, "R6 no overflow", overflow, 0);
    drain(n, 5, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R6 no second event", out_valid, 0);
  endtask

  task automatic t_gaps();
    int n;
    gap_mode = 1'b1;
    repeat (900) @(posedge clk);
    fire(50, 1'b0, n);
    repeat (40) @(posedge clk);
    drain(n, 50, 1'b1, 1'b1);    // R10
    gap_mode = 1'b0;
  endtask

  task automatic t_overflow();
    int na;
    int nb;
    int nc;
    fire(100, 1'b0, na);
    repeat (40) @(posedge clk);
    fire(7, 1'b0, nb);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(overflow == 1'b0, "R7 no overflow yet", overflow, 0);
    fire(250, 1'b0, nc);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow set", overflow, 1);
    chk(buf_full == 2'b11, "R7 buffers still full", buf_full, 3);
    drain(na, 100, 1'b0, 1'b0);
    drain(nb, 7, 1'b1, 1'b1);
    @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    chk(out_valid == 1'b0, "R7 dropped trigger left no event", out_valid, 0);
    do_reset();
    chk(overflow == 1'b0, "R8 overflow cleared by reset", overflow, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_lookback();
    t_clamp();
    t_pingpong();
    t_busy_ignore();
    t_gaps();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule